// File: doc/BRIEF.md
# PCM Bit Clock and Frame Sync Generator

This block produces the serial bit clock and the frame-sync strobe for a PCM audio port. Software programs one control word through a simple write port. The word holds a run enable, a choice of clock source, a bit-clock divisor and a frame divisor. The whole block runs on the bus clock. The audio reference clock enters as a single-cycle tick qualifier, `aud_tick_i`. Choosing the bus clock as the source turns every bus cycle into a source tick.

The bit clock toggles after every (bit divisor + 1) source ticks, so its period is 2*(bit divisor + 1) source ticks and its duty cycle is 50%. The frame divisor counts bit-clock periods, not source ticks. The frame strobe rises together with the bit clock, stays high for exactly one bit-clock period, and repeats every (frame divisor + 1) bit-clock periods. A divisor written while the generator is running is used only from the next wrap of its own counter. A downstream shift engine can use the one-cycle `bclk_rise_o` pulse as its capture qualifier.

Top module: `pcm_clkgen`

## Requirements
- R1: The control word maps as follows: run enable at bit 19, source select at bit 18, bit-clock divisor in bits 17:9, frame divisor in bits 8:0. A write stores bits 19:0. The readback returns those stored bits, and bits 31:20 always read as zero.
- R2: After reset the readback is zero, and `bclk_o`, `bclk_rise_o` and `fsync_o` are low.
- R3: While the run enable is zero the counters are held cleared and all three outputs are low. Clearing the enable forces the outputs low on the second bus clock edge after the write.
- R4: With source select 0, only cycles with `aud_tick_i` high advance the bit-clock divider. With source select 1, every bus cycle advances it.
- R5: Once enabled, `bclk_o` starts low. It toggles after every (bit divisor + 1) source ticks. Tick counting begins on the second bus clock edge after the enable is written.
- R6: `fsync_o` changes only where `bclk_o` rises. It goes high at the first rising bit-clock edge after enable, stays high for one bit-clock period, and repeats every (frame divisor + 1) bit-clock periods. A frame divisor of 0 holds it high.
- R7: `bclk_rise_o` is high for exactly the one bus cycle in which `bclk_o` has just gone high.
- R8: A bit divisor written while running takes effect only after the current half period ends at its toggle.
- R9: A frame divisor written while running takes effect only at the next frame-counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every register uses it |
| rst_n | input | 1 | Synchronous active-low reset |
| aud_tick_i | input | 1 | One-cycle tick from the audio reference clock |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | BUS_W | Control word write data |
| ctl_rdata_o | output | BUS_W | Control word readback |
| bclk_o | output | 1 | Serial bit clock |
| bclk_rise_o | output | 1 | Pulse in the cycle bclk_o has just risen |
| fsync_o | output | 1 | Frame-sync strobe, one bit-clock period wide |

## Verification
The bench drives both sources. It uses divisor values of zero and 511, where an off-by-one in a wrap compare would stretch or shorten every half period. It rewrites divisors in the middle of a half period or a frame; a design that reloaded them at once would show a half period or frame of the wrong length. It drops the enable in the middle of a period to catch outputs that stay high or counters that resume where they left off. It also holds the audio ticks off under audio select; a wrong source mux would keep toggling there.

// File: rtl/pcm_clkgen_pkg.sv
// Shared widths, field positions and the control word type.
// The field order of ctl_t is fixed because software decodes it.
package pcm_clkgen_pkg;
    localparam int DIV_W   = 9;
    localparam int CTL_W   = 2 * DIV_W + 2;
    localparam int EN_BIT  = CTL_W - 1;
    localparam int SEL_BIT = CTL_W - 2;

    typedef struct packed {
        logic             run_en;
        logic             src_bus;
        logic [DIV_W-1:0] bit_div;
        logic [DIV_W-1:0] frm_div;
    } ctl_t;
endpackage

// File: rtl/pcm_clkgen_ctl.sv
// Control word register.
// Stores the low CTL_W bits of every write; reserved upper bits read as zero.
// Assumes BUS_W > CTL_W.
module pcm_clkgen_ctl
    import pcm_clkgen_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [BUS_W-1:0] wr_data_i,
    output ctl_t             ctl_o,
    output logic [BUS_W-1:0] rdata_o
);
    localparam int RSVD_W = BUS_W - CTL_W;

    ctl_t ctl_q;

    // Capture the control fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en_i) begin
            ctl_q <= ctl_t'(wr_data_i[CTL_W-1:0]);
        end
    end

    assign ctl_o   = ctl_q;
    assign rdata_o = {{RSVD_W{1'b0}}, ctl_q};

    AST_RSVD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && |wr_data_i[BUS_W-1:CTL_W]) |=> (rdata_o[BUS_W-1:CTL_W] == '0)); // R1
    AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (rdata_o[CTL_W-1:0] == $past(wr_data_i[CTL_W-1:0]))); // R1
endmodule

// File: rtl/pcm_clkgen_bdiv.sv
// Bit clock divider.
// Counts source ticks and toggles the bit clock after div+1 ticks.
// The divisor is reloaded only at each toggle, or while the block is idle.
// The first cycle after enable only arms the divider.
module pcm_clkgen_bdiv
    import pcm_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             run_o,
    output logic             bclk_o,
    output logic             rise_evt_o,
    output logic             rise_o
);
    logic             run_q;
    logic             bclk_q;
    logic             rise_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] act_q;
    logic             wrap;

    // A wrap is a counted tick on the last count of a half period.
    assign wrap       = run_q && tick_i && (cnt_q == act_q);
    assign rise_evt_o = wrap && !bclk_q;

    // Idle clear, arm on enable, then count ticks and toggle on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            bclk_q <= 1'b0;
            rise_q <= 1'b0;
            cnt_q  <= '0;
            act_q  <= '0;
        end else if (!en_i) begin
            run_q  <= 1'b0;
            bclk_q <= 1'b0;
            rise_q <= 1'b0;
            cnt_q  <= '0;
            act_q  <= div_i;
        end else if (!run_q) begin
            run_q  <= 1'b1;
            bclk_q <= 1'b0;
            rise_q <= 1'b0;
            cnt_q  <= '0;
            act_q  <= div_i;
        end else begin
            rise_q <= rise_evt_o;
            if (wrap) begin
                cnt_q  <= '0;
                bclk_q <= !bclk_q;
                act_q  <= div_i;
            end else if (tick_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign run_o  = run_q;
    assign bclk_o = bclk_q;
    assign rise_o = rise_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= act_q)); // R5
    AST_TOGGLE_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i && run_q && !wrap) |-> (bclk_q == $past(bclk_q))); // R5
    AST_BIT_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i && run_q && !wrap) |-> (act_q == $past(act_q))); // R8
endmodule

// File: rtl/pcm_clkgen_fdiv.sv
// Frame divider.
// Counts rising bit-clock edges. The strobe is high for the bit-clock
// period that starts where the count is zero.
// Assumes rise_evt_i marks the bus cycle in which the bit clock rises.
module pcm_clkgen_fdiv
    import pcm_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             run_i,
    input  logic             rise_evt_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             fsync_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] act_q;
    logic             fs_q;
    logic             fwrap;

    assign fwrap = rise_evt_i && (cnt_q == act_q);

    // Clear while idle; on each rising bit-clock edge, update the strobe and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
            fs_q  <= 1'b0;
        end else if (!en_i || !run_i) begin
            cnt_q <= '0;
            act_q <= div_i;
            fs_q  <= 1'b0;
        end else if (rise_evt_i) begin
            fs_q <= (cnt_q == '0);
            if (fwrap) begin
                cnt_q <= '0;
                act_q <= div_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign fsync_o = fs_q;

    AST_FRM_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && run_i) |-> (cnt_q <= act_q)); // R6
    AST_FRM_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i && run_i && !fwrap) |-> (act_q == $past(act_q))); // R9
endmodule

// File: rtl/pcm_clkgen.sv
// PCM bit clock and frame sync generator, top level.
// Runs on the bus clock. The audio reference clock arrives as a tick qualifier.
// Selecting the bus source makes every bus cycle a tick.
module pcm_clkgen
    import pcm_clkgen_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aud_tick_i,
    input  logic             wr_en_i,
    input  logic [BUS_W-1:0] wr_data_i,
    output logic [BUS_W-1:0] ctl_rdata_o,
    output logic             bclk_o,
    output logic             bclk_rise_o,
    output logic             fsync_o
);
    ctl_t ctl;
    logic src_tick;
    logic run;
    logic rise_evt;

    pcm_clkgen_ctl #(.BUS_W(BUS_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .ctl_o     (ctl),
        .rdata_o   (ctl_rdata_o)
    );

    // Source select: the bus clock ticks every cycle; the audio clock ticks on aud_tick_i.
    assign src_tick = ctl.src_bus ? 1'b1 : aud_tick_i;

    pcm_clkgen_bdiv u_bdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctl.run_en),
        .tick_i     (src_tick),
        .div_i      (ctl.bit_div),
        .run_o      (run),
        .bclk_o     (bclk_o),
        .rise_evt_o (rise_evt),
        .rise_o     (bclk_rise_o)
    );

    pcm_clkgen_fdiv u_fdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctl.run_en),
        .run_i      (run),
        .rise_evt_i (rise_evt),
        .div_i      (ctl.frm_div),
        .fsync_o    (fsync_o)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.run_en |=> (!bclk_o && !fsync_o && !bclk_rise_o)); // R3
    AST_SYNC_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_o) |-> $rose(bclk_o)); // R6
    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_rise_o |-> (bclk_o && !$past(bclk_o))); // R7
endmodule

// File: tb/sim_pcm_clkgen.sv
`timescale 1ns/1ps
module sim_pcm_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aud_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctl_rdata;
    logic        bclk, bclk_rise, fsync;

    int    n_chk = 0, n_fail = 0, cyc = 0, tick_pct = 50;
    bit    mon_on = 0, done = 0, t_smp = 0;
    string cur_tag = "R5";

    int en_p1, en_p2, sel_p, d_pend, y_pend, d_cur, y_cur, ticks, pos;
    bit exp_b, exp_f, exp_r;

    always #4 clk = ~clk;

    pcm_clkgen #(.BUS_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .aud_tick_i(aud_tick), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .ctl_rdata_o(ctl_rdata), .bclk_o(bclk),
        .bclk_rise_o(bclk_rise), .fsync_o(fsync)
    );

    function automatic logic [31:0] mk(bit en, bit sel, int bd, int fd);
        logic [8:0] b = bd[8:0];
        logic [8:0] f = fd[8:0];
        return {12'h000, en, sel, b, f};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic wr(logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Audio ticks at a chosen rate, changed away from the active edge.
    always @(negedge clk) aud_tick = ($urandom_range(99) < tick_pct);
    always @(posedge clk) t_smp = aud_tick;

    // Expected outputs from the requirements, checked every cycle.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            en_p1 = 0; en_p2 = 0; sel_p = 0; d_pend = 0; y_pend = 0;
            d_cur = 0; y_cur = 0; ticks = 0; pos = 0;
            exp_b = 0; exp_f = 0; exp_r = 0;
        end else begin
            exp_r = 0;
            if (en_p1 == 0) begin
                exp_b = 0; exp_f = 0; ticks = 0; pos = 0;
            end else if (en_p2 == 0) begin
                d_cur = d_pend; y_cur = y_pend; ticks = 0; pos = 0;
                exp_b = 0; exp_f = 0;
            end else if (sel_p != 0 || t_smp) begin
                if (ticks == d_cur) begin
                    ticks = 0;
                    exp_b = !exp_b;
                    d_cur = d_pend;
                    if (exp_b) begin
                        exp_r = 1;
                        exp_f = (pos == 0);
                        if (pos == y_cur) begin
                            pos = 0;
                            y_cur = y_pend;
                        end else begin
                            pos++;
                        end
                    end
                end else begin
                    ticks++;
                end
            end
            if (mon_on) begin
                chk(bclk == exp_b, (en_p1 != 0) ? {"R5 ", cur_tag} : "R3", "bclk", bclk, exp_b);
                chk(fsync == exp_f, (en_p1 != 0) ? {"R6 ", cur_tag} : "R3", "fsync", fsync, exp_f);
                chk(bclk_rise == exp_r, "R7", "bclk_rise", bclk_rise, exp_r);
            end
            en_p2 = en_p1;
            en_p1 = ctl_rdata[19];
            sel_p = ctl_rdata[18];
            d_pend = ctl_rdata[17:9];
            y_pend = ctl_rdata[8:0];
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R5 watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        idle(5);
        chk(ctl_rdata == 32'h0, "R2", "reset readback", ctl_rdata, 0);
        chk(bclk == 1'b0 && fsync == 1'b0 && bclk_rise == 1'b0, "R2", "reset outputs",
            {bclk, fsync, bclk_rise}, 0);
        rst_n = 1'b1;
        mon_on = 1;

        // R1: reserved bits are dropped, fields stored.
        wr(32'hFFF0_0000 | mk(0, 1, 5, 3));
        chk(ctl_rdata == mk(0, 1, 5, 3), "R1", "readback", ctl_rdata, mk(0, 1, 5, 3));
        wr(32'hFFFF_FFFF);
        chk(ctl_rdata == 32'h000F_FFFF, "R1", "reserved read", ctl_rdata, 32'h000F_FFFF);
        wr(mk(0, 1, 5, 3));
        idle(40);
        chk(bclk == 1'b0, "R3", "disabled bclk", bclk, 0);

        // R4: audio source with no ticks must not advance.
        cur_tag = "R4";
        tick_pct = 0;
        wr(mk(1, 0, 2, 1));
        idle(100);
        chk(bclk == 1'b0, "R4", "no audio ticks", bclk, 0);
        tick_pct = 100;
        idle(60);
        tick_pct = 50;
        idle(80);

        // R5 R6: smallest divisors, then the largest bit divisor.
        cur_tag = "R5";
        wr(mk(1, 1, 0, 0));
        idle(40);
        chk(fsync == 1'b1, "R6", "frame div 0 holds high", fsync, 1);
        wr(mk(0, 1, 0, 0));
        wr(mk(1, 1, 511, 2));
        idle(3500);

        // R3: disable in the middle of a period.
        wr(mk(1, 1, 3, 2));
        idle(11);
        wr(mk(0, 1, 3, 2));
        @(negedge clk);
        chk(bclk == 1'b0 && fsync == 1'b0, "R3", "disable clears", {bclk, fsync}, 0);
        idle(10);

        // R8: bit divisor rewritten mid half period.
        cur_tag = "R8";
        wr(mk(1, 1, 3, 2));
        idle(37);
        wr(mk(1, 1, 6, 2));
        idle(150);
        wr(mk(1, 1, 1, 2));
        idle(60);

        // R9: frame divisor rewritten mid frame.
        cur_tag = "R9";
        wr(mk(1, 1, 1, 4));
        idle(23);
        wr(mk(1, 1, 1, 1));
        idle(80);
        wr(mk(1, 1, 1, 6));
        idle(120);

        // Random scenarios mixing sources, divisors, rewrites and disables.
        for (int s = 0; s < 30; s++) begin
            int sel = $urandom_range(1);
            int bd  = $urandom_range(9);
            int fd  = $urandom_range(6);
            cur_tag = "R5";
            tick_pct = $urandom_range(100, 20);
            wr(mk(1, sel[0], bd, fd));
            idle($urandom_range(300, 40));
            if ($urandom_range(1) == 1) begin
                cur_tag = "R8";
                wr(mk(1, sel[0], $urandom_range(9), $urandom_range(6)));
                idle($urandom_range(200, 30));
            end
            if ($urandom_range(4) == 0) begin
                cur_tag = "R3";
                wr(mk(0, sel[0], bd, fd));
                idle($urandom_range(5, 1));
            end
        end
        tick_pct = 50;
        wr(mk(0, 0, 0, 0));
        idle(5);
        chk(bclk == 1'b0 && fsync == 1'b0, "R3", "final idle", {bclk, fsync}, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule